// File: doc/BRIEF.md
# Serial Flash Write-Enable Guard

This block sits at the slave end of a serial flash command port and owns the write-enable latch. An opcode byte arrives on a SPI-style link: chip select low, serial clock, data in. The byte is sampled on rising serial-clock edges, most significant bit first. Two one-byte commands arm and disarm the latch. Every command that alters the memory or its status register is allowed to start only while the latch is armed and no earlier operation is still running. Each such command produces a one-cycle accept or reject pulse in the system clock domain.

An accepted command raises a busy flag. An external done pulse marks the end of the operation and clears both busy and the latch, so every further write needs a new arming command. The chip-select, serial-clock and data inputs each pass through a two-flop synchroniser into the system clock. The serial clock must therefore be slow compared with the system clock. The data-out enable stays low, because no command handled here drives data back.

Top module: `wel_guard`

## Requirements
- R1: After reset the latch and busy are low and neither accept nor reject pulses.
- R2: A frame of exactly 8 bits carrying 06h, sampled MSB first on rising serial-clock edges, sets the latch when chip select rises.
- R3: A frame of exactly 8 bits carrying 04h clears the latch when chip select rises.
- R4: A frame of any other length (1 to 7 bits, or 9 or more bits) leaves the latch unchanged, even when its first byte is 06h or 04h.
- R5: Each of the modifying opcodes 02h, A2h, 32h, 42h, 20h, D8h, C7h and 01h gives exactly one accept pulse when its first byte is captured, provided the latch is set and busy is low. Busy then goes high.
- R6: A modifying opcode issued while the latch is clear gives exactly one reject pulse, and busy stays low.
- R7: A modifying opcode issued while busy is high gives exactly one reject pulse, even when the latch is set.
- R8: A done pulse while busy is high clears both busy and the latch on the next cycle. A done pulse while busy is low changes nothing.
- R9: Every opcode that is neither modifying nor 06h/04h gives no pulse and leaves the latch and busy unchanged.
- R10: The data-out enable stays low at all times, including through enable and disable frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| op_done | input | 1 | One-cycle pulse marking the end of a running operation |
| wel | output | 1 | Write-enable latch state |
| busy | output | 1 | A modifying operation has been accepted and is not yet done |
| cmd_accept | output | 1 | One-cycle pulse: modifying command allowed to start |
| cmd_reject | output | 1 | One-cycle pulse: modifying command refused |
| sdo_oe | output | 1 | Data-out drive enable |

## Verification
All 256 opcode values are sent with the latch armed. This separates the eight modifying codes (one accept each, then busy), the two latch commands, and every other code (no pulse, no change). The eight modifying codes are then sent again with the latch clear, and again while busy. These runs tell the reject cause apart from the accept path. Frame lengths from 1 to 16 bits are swept for both latch commands, starting from the opposite latch state, so that only the exact 8-bit frame may change the latch. Done pulses are sent both while idle and while busy to check that the clear happens only when an operation has really ended.

// File: rtl/wel_guard.sv
module wel_guard #(
  parameter int OPW = 8,
  parameter logic [OPW-1:0] OP_SET = 8'h06,
  parameter logic [OPW-1:0] OP_CLR = 8'h04
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  input  logic op_done,
  output logic wel,
  output logic busy,
  output logic cmd_accept,
  output logic cmd_reject,
  output logic sdo_oe
);
  localparam int CW = $clog2(OPW + 2);
  localparam logic [CW-1:0] N_LAST = CW'(OPW - 1);
  localparam logic [CW-1:0] N_FULL = CW'(OPW);
  localparam logic [CW-1:0] N_OVER = CW'(OPW + 1);

  logic [2:0]     sck_q, cs_q;
  logic [1:0]     sdi_q;
  logic [CW-1:0]  nbit;
  logic [OPW-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      cs_q  <= {cs_q[1:0], cs_n};
      sdi_q <= {sdi_q[0], sdi};
    end

  wire cs_hi  = cs_q[1];
  wire cs_up  = cs_q[1] & ~cs_q[2];
  wire sk_up  = sck_q[1] & ~sck_q[2] & ~cs_hi;
  wire [OPW-1:0] byte_now = {shreg[OPW-2:0], sdi_q[1]};
  wire cap    = sk_up && (nbit == N_LAST);

  function automatic logic is_mod(input logic [OPW-1:0] op);
    case (op)
      8'h02, 8'hA2, 8'h32, 8'h42, 8'h20, 8'hD8, 8'hC7, 8'h01: is_mod = 1'b1;
      default: is_mod = 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nbit  <= '0;
      shreg <= '0;
    end else if (cs_hi) begin
      nbit <= '0;
    end else if (sk_up) begin
      shreg <= byte_now;
      if (nbit != N_OVER) nbit <= nbit + 1'b1;
    end

  wire frame_ok = cs_up && (nbit == N_FULL);
  wire mod_now  = cap && is_mod(byte_now);
  wire go       = mod_now && wel && !busy;
  wire finish   = busy && op_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel        <= 1'b0;
      busy       <= 1'b0;
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_accept <= go;
      cmd_reject <= mod_now && !go;
      if (finish) wel <= 1'b0;
      else if (frame_ok && shreg == OP_SET) wel <= 1'b1;
      else if (frame_ok && shreg == OP_CLR) wel <= 1'b0;
      if (finish) busy <= 1'b0;
      else if (go) busy <= 1'b1;
    end

  assign sdo_oe = 1'b0;

  p_accept_needs_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> $past(wel) && !$past(busy));
  p_accept_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |-> busy);
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject));
  p_busy_rejects_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && cmd_reject |-> busy);
  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_done |=> !busy && !wel);
  p_busy_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_accept);
endmodule

// File: tb/wel_guard_tb.sv
module wel_guard_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, op_done = 1'b0;
  logic wel, busy, cmd_accept, cmd_reject, sdo_oe;
  int n_chk = 0, n_fail = 0, n_acc = 0, n_rej = 0, n_oe = 0;

  always #10 clk = ~clk;

  wel_guard dut_i (.clk, .rst_n, .cs_n, .sck, .sdi, .op_done,
                   .wel, .busy, .cmd_accept, .cmd_reject, .sdo_oe);

  always @(negedge clk) begin
    if (cmd_accept) n_acc++;
    if (cmd_reject) n_rej++;
    if (sdo_oe) n_oe++;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] v, int n);
    cs_n = 1'b0;
    repeat (4) @(posedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      repeat (3) @(posedge clk);
      sck = 1'b1;
      repeat (3) @(posedge clk);
      sck = 1'b0;
    end
    repeat (3) @(posedge clk);
    cs_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic done_pulse();
    @(posedge clk); op_done = 1'b1;
    @(posedge clk); op_done = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit is_mod(int op);
    return op == 8'h02 || op == 8'hA2 || op == 8'h32 || op == 8'h42 ||
           op == 8'h20 || op == 8'hD8 || op == 8'hC7 || op == 8'h01;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a0, r0;
    int mods[8] = '{8'h02, 8'hA2, 8'h32, 8'h42, 8'h20, 8'hD8, 8'hC7, 8'h01};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 wel", wel, 0);
    check("R1 busy", busy, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 pulses", n_acc + n_rej, 0);

    send(16'h06, 8);
    check("R2 set", wel, 1);
    send(16'h04, 8);
    check("R3 clear", wel, 0);

    for (int op = 0; op < 256; op++) begin
      send(16'h06, 8);
      a0 = n_acc; r0 = n_rej;
      send(16'(op), 8);
      if (is_mod(op)) begin
        check("R5 accept", n_acc - a0, 1);
        check("R5 no reject", n_rej - r0, 0);
        check("R5 busy", busy, 1);
        done_pulse();
        check("R8 busy clear", busy, 0);
        check("R8 wel clear", wel, 0);
      end else begin
        check("R9 no pulse", n_acc + n_rej - a0 - r0, 0);
        check("R9 busy", busy, 0);
        check(op == 8'h04 ? "R3 wel" : op == 8'h06 ? "R2 wel" : "R9 wel",
              wel, op == 8'h04 ? 0 : 1);
      end
    end

    send(16'h04, 8);
    foreach (mods[k]) begin
      a0 = n_acc; r0 = n_rej;
      send(16'(mods[k]), 8);
      check("R6 reject", n_rej - r0, 1);
      check("R6 no accept", n_acc - a0, 0);
      check("R6 busy", busy, 0);
    end

    foreach (mods[k]) begin
      send(16'h06, 8);
      send(16'h02, 8);
      send(16'h06, 8);
      a0 = n_acc; r0 = n_rej;
      send(16'(mods[k]), 8);
      check("R7 reject", n_rej - r0, 1);
      check("R7 no accept", n_acc - a0, 0);
      check("R7 busy", busy, 1);
      done_pulse();
      check("R8 after busy", wel + busy, 0);
    end

    send(16'h06, 8);
    done_pulse();
    check("R8 idle done wel", wel, 1);
    check("R8 idle done busy", busy, 0);

    for (int n = 1; n <= 16; n++) begin
      send(16'h04, 8);
      send(16'h0606 >> (16 - n), n);
      check(n == 8 ? "R2 length" : "R4 set length", wel, n == 8 ? 1 : 0);
      send(16'h06, 8);
      send(16'h0404 >> (16 - n), n);
      check(n == 8 ? "R3 length" : "R4 clear length", wel, n == 8 ? 0 : 1);
    end

    check("R10 sdo_oe", n_oe, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule